// File: doc/BRIEF.md
# I2C Slave Address and General-Call Decision Unit

This block is the front end of an I2C target. It watches already-synchronized SCL and SDA samples and finds start, stop and repeated-start conditions. After a start it shifts in the address byte, MSB first on each SCL rising edge, and decides whether to acknowledge it. It then pulls SDA low during the ninth clock when it acknowledges. Two kinds of address are accepted: the programmed 7-bit own address in either direction, and, when enabled, the all-zero general-call address with a write direction.

Once a general call has been acknowledged, the first data byte after it can be compared with a stored match value. A match marks a hardware general call, which lets a device that needs attention announce itself. The block keeps sticky status for general calls and for bus events, and raises an interrupt for the bus events that are enabled. It produces a one-cycle transmit-request strobe for read transfers, either after the address acknowledge or early, right after the direction bit. Software can also ask it to refuse the next transfer addressed to it.

Top module: `i2c_gc_addr_ctrl`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start seen while a transfer is in progress (any time after a start and before a stop) sets the sticky `rstart_o` flag. A start from idle does not set it. A stop sets the sticky `stop_o` flag.
- R2: An address byte whose upper 7 bits equal `own_addr_i` is acknowledged in both directions; any other non-general-call byte is not. The acknowledge pulls `sda_low_o` high from the SCL fall after the 8th bit until the SCL fall after the 9th bit, and it only ever starts while SCL is low.
- R3: Address byte 0x00 (general call, write) is acknowledged only while `gc_en_i` is 1. Byte 0x01 is never acknowledged as a general call.
- R4: An acknowledged general call sets `gc_stat_o` to 1 and sets `gc_id_o` to 1 (encoding: 0 = none, 1 = general call, 2 = hardware general call), unless it is already 2.
- R5: When `gc_en_i` and `hgc_en_i` are both 1, the first data byte after an acknowledged general call is compared with `alt_i`. It sets `gc_id_o` to 2 only if it is equal to `alt_i` and bit 0 of `alt_i` is 1. Any other first byte leaves `gc_id_o` at 1.
- R6: `gc_stat_o` and `gc_id_o` never drop except when a 1 is applied on `gc_clr_i` or on reset. Later transfers and stops leave them unchanged.
- R7: A pulse on `nack_set_i` sets `nack_pend_o`. The next address byte that would have been acknowledged is refused and `nack_pend_o` clears. The transfer after that is acknowledged again.
- R8: For an acknowledged read address, `tx_req_o` pulses once for one cycle. With `early_tx_i` = 0 it follows the SCL rising edge of the 9th (acknowledge) bit. With `early_tx_i` = 1 it follows the rising edge of the 8th (direction) bit. A refused read produces no pulse.
- R9: `rstart_o` and `stop_o` clear only on `evt_clr_i` or reset. `irq_o` is the registered OR of (`rstart_o` AND `ien_rstart_i`) and (`stop_o` AND `ien_stop_i`).
- R10: Every data byte of an acknowledged write transfer is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| own_addr_i | input | 7 | Own 7-bit address (nonzero) |
| gc_en_i | input | 1 | Accept general call |
| hgc_en_i | input | 1 | Enable hardware general call compare |
| alt_i | input | 8 | Hardware general call match value |
| early_tx_i | input | 1 | Raise transmit request after the direction bit |
| nack_set_i | input | 1 | Pulse: refuse the next addressed transfer |
| gc_clr_i | input | 1 | Clear general-call status and ID |
| evt_clr_i | input | 1 | Clear repeated-start and stop flags |
| ien_rstart_i | input | 1 | Interrupt enable for repeated start |
| ien_stop_i | input | 1 | Interrupt enable for stop |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| tx_req_o | output | 1 | One-cycle transmit request strobe |
| gc_stat_o | output | 1 | Sticky general call received |
| gc_id_o | output | 2 | Sticky general call kind |
| rstart_o | output | 1 | Sticky repeated start seen |
| stop_o | output | 1 | Sticky stop seen |
| irq_o | output | 1 | Interrupt request |
| nack_pend_o | output | 1 | One-shot refusal armed |

## Verification
The bench checks when the transmit-request strobe fires against the bit count of the transfer. A design that mixed up early and normal mode would pulse on the wrong clock, and one that ignored a refusal would produce a pulse nothing expects. It sends a general call followed by a matching byte and then a mismatching one, and checks that the ID only moves upward and then holds through later transfers and stops until it is cleared. A design that compared without the low-bit rule, or that let a plain call overwrite a hardware one, would report the wrong ID. It also sends a repeated start after an acknowledged address and a fresh start from idle, so that a design counting every start as a repeat is caught. Finally it arms the one-shot refusal and sends two back-to-back addressed transfers: the first must be refused, and the second must be acknowledged again.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK, ST_SKIP
  } fsm_st_t;

  typedef enum logic [1:0] {
    PH_WAIT_FALL = 2'd0, PH_DRIVE = 2'd1, PH_END = 2'd2
  } ack_ph_t;

  localparam logic [1:0] GCID_NONE = 2'd0;
  localparam logic [1:0] GCID_GC   = 2'd1;
  localparam logic [1:0] GCID_HW   = 2'd2;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;
endmodule

// File: rtl/i2c_gc_fsm.sv
module i2c_gc_fsm
  import i2c_gc_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              scl_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  input  logic              hgc_en_i,
  input  logic [ADDR_W:0]   alt_i,
  input  logic              early_tx_i,
  input  logic              nack_set_i,
  output logic              sda_low_o,
  output logic              tx_req_o,
  output logic              gc_hit_o,
  output logic              hgc_hit_o,
  output logic              rstart_hit_o,
  output logic              nack_pend_o
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  fsm_st_t           state;
  ack_ph_t           ph;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] byte_nx;
  logic [CNT_W-1:0]  cnt;
  logic              ack_q, rw_q, gc_q, first_q;
  logic              own_m, gc_m, hit;

  assign byte_nx = {shreg[BYTE_W-2:0], sda_i};
  assign own_m   = (byte_nx[BYTE_W-1:1] == own_addr_i);
  assign gc_m    = gc_en_i && (byte_nx == '0);
  assign hit     = own_m || gc_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      ph           <= PH_WAIT_FALL;
      shreg        <= '0;
      cnt          <= '0;
      ack_q        <= 1'b0;
      rw_q         <= 1'b0;
      gc_q         <= 1'b0;
      first_q      <= 1'b0;
      sda_low_o    <= 1'b0;
      tx_req_o     <= 1'b0;
      gc_hit_o     <= 1'b0;
      hgc_hit_o    <= 1'b0;
      rstart_hit_o <= 1'b0;
      nack_pend_o  <= 1'b0;
    end else begin
      tx_req_o     <= 1'b0;
      gc_hit_o     <= 1'b0;
      hgc_hit_o    <= 1'b0;
      rstart_hit_o <= 1'b0;
      if (start_i) begin
        rstart_hit_o <= (state != ST_IDLE);
        state        <= ST_ADDR;
        cnt          <= '0;
        sda_low_o    <= 1'b0;
      end else if (stop_i) begin
        state     <= ST_IDLE;
        sda_low_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (rise_i) begin
            shreg <= byte_nx;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              state <= ST_ADDR_ACK;
              ph    <= PH_WAIT_FALL;
              rw_q  <= byte_nx[0];
              gc_q  <= gc_m && !own_m;
              ack_q <= hit && !nack_pend_o;
              if (hit) nack_pend_o <= 1'b0;
              if (hit && !nack_pend_o && gc_m && !own_m) gc_hit_o <= 1'b1;
              if (hit && !nack_pend_o && early_tx_i && byte_nx[0]) tx_req_o <= 1'b1;
            end
          end
          ST_DATA: if (rise_i) begin
            shreg <= byte_nx;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              state   <= ST_DATA_ACK;
              ph      <= PH_WAIT_FALL;
              ack_q   <= 1'b1;
              first_q <= 1'b0;
              if (first_q && gc_q && gc_en_i && hgc_en_i && alt_i[0] && byte_nx == alt_i)
                hgc_hit_o <= 1'b1;
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            unique case (ph)
              PH_WAIT_FALL: if (fall_i) begin
                sda_low_o <= ack_q;
                ph        <= PH_DRIVE;
              end
              PH_DRIVE: if (rise_i) begin
                ph <= PH_END;
                if (state == ST_ADDR_ACK && !early_tx_i && ack_q && rw_q) tx_req_o <= 1'b1;
              end
              default: if (fall_i) begin
                sda_low_o <= 1'b0;
                cnt       <= '0;
                if (state == ST_ADDR_ACK) first_q <= 1'b1;
                state <= (ack_q && !rw_q) ? ST_DATA : ST_SKIP;
              end
            endcase
          end
          default: ;
        endcase
      end
      if (nack_set_i) nack_pend_o <= 1'b1;
    end
  end

  assert_ack_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low_o) |-> !scl_i);
  assert_txreq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    tx_req_o |=> !tx_req_o);
  assert_gc_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
    gc_hit_o |-> $past(gc_en_i));
  assert_hgc_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
    hgc_hit_o |-> $past(hgc_en_i && alt_i[0]));
endmodule

// File: rtl/i2c_gc_status.sv
module i2c_gc_status
  import i2c_gc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       gc_hit_i,
  input  logic       hgc_hit_i,
  input  logic       rstart_hit_i,
  input  logic       stop_hit_i,
  input  logic       gc_clr_i,
  input  logic       evt_clr_i,
  input  logic       ien_rstart_i,
  input  logic       ien_stop_i,
  output logic       gc_stat_o,
  output logic [1:0] gc_id_o,
  output logic       rstart_o,
  output logic       stop_o,
  output logic       irq_o
);
  logic [1:0] id_base, id_nx;

  always_comb begin
    id_base = gc_clr_i ? GCID_NONE : gc_id_o;
    id_nx   = id_base;
    if (gc_hit_i && id_base == GCID_NONE) id_nx = GCID_GC;
    if (hgc_hit_i) id_nx = GCID_HW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gc_stat_o <= 1'b0;
      gc_id_o   <= GCID_NONE;
      rstart_o  <= 1'b0;
      stop_o    <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      gc_id_o   <= id_nx;
      gc_stat_o <= (gc_stat_o && !gc_clr_i) || gc_hit_i;
      rstart_o  <= (rstart_o && !evt_clr_i) || rstart_hit_i;
      stop_o    <= (stop_o && !evt_clr_i) || stop_hit_i;
      irq_o     <= (rstart_o && ien_rstart_i) || (stop_o && ien_stop_i);
    end
  end

  assert_gcid_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !gc_clr_i |=> (gc_id_o >= $past(gc_id_o)));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past((rstart_o && ien_rstart_i) || (stop_o && ien_stop_i)));
endmodule

// File: rtl/i2c_gc_addr_ctrl.sv
module i2c_gc_addr_ctrl #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  input  logic              hgc_en_i,
  input  logic [ADDR_W:0]   alt_i,
  input  logic              early_tx_i,
  input  logic              nack_set_i,
  input  logic              gc_clr_i,
  input  logic              evt_clr_i,
  input  logic              ien_rstart_i,
  input  logic              ien_stop_i,
  output logic              sda_low_o,
  output logic              tx_req_o,
  output logic              gc_stat_o,
  output logic [1:0]        gc_id_o,
  output logic              rstart_o,
  output logic              stop_o,
  output logic              irq_o,
  output logic              nack_pend_o
);
  logic start_w, stop_w, rise_w, fall_w;
  logic gc_hit_w, hgc_hit_w, rstart_hit_w;

  i2c_bus_cond cond_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w)
  );

  i2c_gc_fsm #(.ADDR_W(ADDR_W)) fsm_i (
    .clk(clk), .rst(rst), .sda_i(sda_i),
    .start_i(start_w), .stop_i(stop_w), .rise_i(rise_w), .fall_i(fall_w),
    .scl_i(scl_i), .own_addr_i(own_addr_i), .gc_en_i(gc_en_i),
    .hgc_en_i(hgc_en_i), .alt_i(alt_i), .early_tx_i(early_tx_i),
    .nack_set_i(nack_set_i), .sda_low_o(sda_low_o), .tx_req_o(tx_req_o),
    .gc_hit_o(gc_hit_w), .hgc_hit_o(hgc_hit_w), .rstart_hit_o(rstart_hit_w),
    .nack_pend_o(nack_pend_o)
  );

  i2c_gc_status status_i (
    .clk(clk), .rst(rst), .gc_hit_i(gc_hit_w), .hgc_hit_i(hgc_hit_w),
    .rstart_hit_i(rstart_hit_w), .stop_hit_i(stop_w), .gc_clr_i(gc_clr_i),
    .evt_clr_i(evt_clr_i), .ien_rstart_i(ien_rstart_i), .ien_stop_i(ien_stop_i),
    .gc_stat_o(gc_stat_o), .gc_id_o(gc_id_o), .rstart_o(rstart_o),
    .stop_o(stop_o), .irq_o(irq_o)
  );
endmodule

// File: tb/i2c_gc_addr_ctrl_tb_top.sv
module i2c_gc_addr_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [6:0] own_addr = 7'h2A;
  logic gc_en = 0, hgc_en = 0, early_tx = 0, nack_set = 0;
  logic gc_clr = 0, evt_clr = 0, ien_rstart = 0, ien_stop = 0;
  logic [7:0] alt = 8'h35;
  logic sda_low, tx_req, gc_stat, rstart, stop_f, irq, nack_pend;
  logic [1:0] gc_id;
  logic sda_bus;
  int checks = 0, errors = 0, bitpos = 0;
  int exp_q[$];
  logic ack;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_low;

  i2c_gc_addr_ctrl dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .own_addr_i(own_addr),
    .gc_en_i(gc_en), .hgc_en_i(hgc_en), .alt_i(alt), .early_tx_i(early_tx),
    .nack_set_i(nack_set), .gc_clr_i(gc_clr), .evt_clr_i(evt_clr),
    .ien_rstart_i(ien_rstart), .ien_stop_i(ien_stop), .sda_low_o(sda_low),
    .tx_req_o(tx_req), .gc_stat_o(gc_stat), .gc_id_o(gc_id), .rstart_o(rstart),
    .stop_o(stop_f), .irq_o(irq), .nack_pend_o(nack_pend)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0; wait_n(2);
  endtask

  task automatic send_start();
    @(negedge clk); sda_m = 1'b1; wait_n(3); scl = 1'b1; wait_n(4);
    sda_m = 1'b0; bitpos = 0; wait_n(4); scl = 1'b0; wait_n(3);
  endtask

  task automatic send_stop();
    @(negedge clk); sda_m = 1'b0; wait_n(3); scl = 1'b1; wait_n(4);
    sda_m = 1'b1; wait_n(6);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sda_m = b[i]; wait_n(3);
      scl = 1'b1; bitpos++; wait_n(4); scl = 1'b0; wait_n(3);
    end
    @(negedge clk); sda_m = 1'b1; wait_n(3);
    scl = 1'b1; bitpos++; wait_n(2); a = sda_low; wait_n(2);
    scl = 1'b0; wait_n(4);
  endtask

  // scoreboard monitor: each strobe must match the bit slot the driver expects
  always @(negedge clk) begin
    if (!rst && tx_req) begin
      if (exp_q.size() == 0) chk("R8 unexpected tx_req", bitpos, 0);
      else chk("R8 tx_req bit slot", bitpos, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    wait_n(4); rst = 1'b0; wait_n(2);
    chk("R2 reset sda_low", sda_low, 0);
    chk("R6 reset gc_id", gc_id, 0);
    chk("R9 reset irq", irq, 0);
    chk("R7 reset nack_pend", nack_pend, 0);

    // own address write, two data bytes
    send_start(); send_byte({7'h2A, 1'b0}, ack); chk("R2 own write ack", ack, 1);
    send_byte(8'h55, ack); chk("R10 data ack", ack, 1);
    send_byte(8'hA3, ack); chk("R10 second data ack", ack, 1);
    send_stop();
    chk("R1 stop flag", stop_f, 1);
    chk("R1 no rstart from idle", rstart, 0);
    chk("R9 irq masked", irq, 0);
    ien_stop = 1; wait_n(3); chk("R9 stop irq", irq, 1);
    pulse(evt_clr); chk("R9 flags cleared", stop_f, 0);
    wait_n(2); chk("R9 irq drops", irq, 0); ien_stop = 0;

    // foreign address
    send_start(); send_byte({7'h11, 1'b0}, ack); chk("R2 foreign nack", ack, 0);
    send_stop();

    // general call disabled, then enabled
    send_start(); send_byte(8'h00, ack); chk("R3 gc disabled nack", ack, 0);
    send_stop(); chk("R4 no gc status", gc_stat, 0);
    gc_en = 1;
    send_start(); send_byte(8'h01, ack); chk("R3 gc read nack", ack, 0); send_stop();
    send_start(); send_byte(8'h00, ack); chk("R3 gc ack", ack, 1);
    send_byte(8'h35, ack); send_stop();
    chk("R4 gc_stat", gc_stat, 1);
    chk("R5 id without hgc_en", gc_id, 1);

    // hardware general call
    hgc_en = 1;
    send_start(); send_byte(8'h00, ack); send_byte(8'h34, ack); send_stop();
    chk("R5 mismatch keeps id", gc_id, 1);
    send_start(); send_byte(8'h00, ack); send_byte(8'h35, ack); send_stop();
    chk("R5 hardware gc id", gc_id, 2);
    send_start(); send_byte(8'h00, ack); send_byte(8'h10, ack); send_stop();
    chk("R6 id held after plain gc", gc_id, 2);
    send_start(); send_byte({7'h2A, 1'b0}, ack); send_stop();
    chk("R6 id held after other transfer", gc_id, 2);
    pulse(gc_clr);
    chk("R6 clear id", gc_id, 0);
    chk("R6 clear stat", gc_stat, 0);
    alt = 8'h34;
    send_start(); send_byte(8'h00, ack); send_byte(8'h34, ack); send_stop();
    chk("R5 even alt never matches", gc_id, 1);

    // one-shot NACK
    pulse(nack_set); chk("R7 armed", nack_pend, 1);
    send_start(); send_byte({7'h2A, 1'b0}, ack); chk("R7 refused", ack, 0);
    send_stop(); chk("R7 self clear", nack_pend, 0);
    send_start(); send_byte({7'h2A, 1'b0}, ack); chk("R7 next acked", ack, 1);
    send_stop();

    // transmit request timing
    exp_q.push_back(9);
    send_start(); send_byte({7'h2A, 1'b1}, ack); send_stop();
    early_tx = 1; exp_q.push_back(8);
    send_start(); send_byte({7'h2A, 1'b1}, ack); send_stop();
    pulse(nack_set);
    send_start(); send_byte({7'h2A, 1'b1}, ack); send_stop();
    chk("R8 refused read", ack, 0);
    early_tx = 0;

    // repeated start
    pulse(evt_clr);
    exp_q.push_back(9);
    send_start(); send_byte({7'h2A, 1'b0}, ack);
    send_start(); send_byte({7'h2A, 1'b1}, ack);
    chk("R1 rstart flag", rstart, 1);
    chk("R9 rstart irq masked", irq, 0);
    ien_rstart = 1; wait_n(3); chk("R9 rstart irq", irq, 1);
    send_stop();
    wait_n(4);
    chk("R8 all strobes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule